// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers up to `NSRC` peripheral interrupt lines, numbered 1 to `NSRC`, and steers them to `NCTX` processor contexts. Every source has a programmable priority. Every context has its own enable mask, a priority threshold and one interrupt output. A context's handler reads its claim register to take the best waiting source. That read clears the source's pending state. The source then stays quiet until the handler writes the same ID back to signal completion. Each source line passes through a gateway that is fixed at build time, by the `EDGE_SRCS` parameter, as either level-high or rising-edge.

Software reaches the block through a 32-bit register port with word addresses. A request is taken when `req_valid` and `req_ready` are both high. A read returns its data one cycle later on `resp_valid`/`resp_data`. That response stays stable until `resp_ready` is high. While a response is held, `req_ready` is low, so no new access can enter. Writes give no response. The side effects of an access, such as clearing a claimed source, happen in the cycle the request is accepted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority, enable and threshold is 0, nothing is pending, every `irq_o` bit is low, and a claim read returns 0.
- R2: The priority of source N is at word address N. It keeps `PRIO_W` bits (default 3) and reads back zero-extended. Word 0 always reads 0 and ignores writes. Any address that is not mapped reads 0.
- R3: The enable word w of context c is at word address 0x800 + 0x20·c + w. Source N is bit N mod 32 of word N/32. Bit 0 of word 0 always reads 0.
- R4: For context c, the threshold is at word 0x80000 + 0x400·c and the claim/complete register is at the next word. `irq_o[c]` is high exactly when some source enabled for c is pending with a priority strictly above c's threshold. A threshold of 7 masks every source.
- R5: A claim read returns the eligible pending source with the highest priority, with the lowest ID winning a tie. It clears that source's pending state in the same access. It returns 0 when no source is eligible.
- R6: A level source that has been claimed does not become pending again before its completion, even if its line stays high. After completion it becomes pending again if the line is still high.
- R7: An edge source records one rising edge that arrives while it is claimed. It forwards that request only after completion.
- R8: A completion write is ignored when the ID is 0, is above `NSRC`, or is not enabled for the context written.
- R9: A source with priority 0 never raises an interrupt and is never returned by a claim.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_data` holds its value and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Source lines; bit N is source N |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read data valid |
| resp_ready | input | 1 | Consumer takes read data |
| resp_data | output | 32 | Read data |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
The bench targets several corner cases. Equal-priority sources are checked for the tie-break: a design that took the highest ID would return the wrong source. The threshold is set equal to a priority to check the comparison: an inclusive compare would raise the interrupt. Level lines are held high across a claim: a gateway that re-arms too early would return the same source twice. An edge pulse is sent while the source is being serviced: a design that forwarded it at once, or dropped it, would either claim too early or never claim again. Completion writes with a foreign context and an out-of-range ID are checked as well: a design that accepted them would release the source. A stalled response checks that the read data and the request back-pressure hold.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // word-address layout of the register space
  localparam int unsigned ENA_WBASE  = 32'h0000_0800;
  localparam int unsigned ENA_WSTEP  = 32'h0000_0020;
  localparam int unsigned CTX_WBASE  = 32'h0008_0000;
  localparam int unsigned CTX_WSTEP  = 32'h0000_0400;
  localparam int unsigned THR_OFS    = 0;
  localparam int unsigned CLAIM_OFS  = 1;

  typedef enum logic [1:0] {
    GW_LEVEL = 2'd0,
    GW_EDGE  = 2'd1
  } gw_kind_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic svc_o
);
  logic pend_q, svc_q, fire, busy;

  assign busy = pend_q | svc_q;

  generate
    if (EDGE) begin : g_edge
      logic src_q, held_q, rise;
      assign rise = src_i & ~src_q;
      assign fire = ~busy & (rise | held_q);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          src_q  <= 1'b0;
          held_q <= 1'b0;
        end else begin
          src_q  <= src_i;
          held_q <= (held_q | rise) & ~fire;
        end
      end
    end else begin : g_level
      assign fire = ~busy & src_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      pend_q <= claim_i ? 1'b0 : (pend_q | fire);
      svc_q  <= claim_i | (svc_q & ~done_i);
    end
  end

  assign pend_o = pend_q;
  assign svc_o  = svc_q;
endmodule

// File: rtl/ctx_arbiter.sv
module ctx_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(NSRC + 1)
) (
  input  logic [NSRC:0]                 pend_i,
  input  logic [NSRC:0]                 en_i,
  input  logic [(NSRC+1)*PRIO_W-1:0]    prio_i,
  input  logic [PRIO_W-1:0]             thr_i,
  output logic [IDW-1:0]                best_id_o,
  output logic                          irq_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict compare against running best: threshold is the floor, lower ID keeps ties
  always_comb begin
    best_prio = thr_i;
    best_id_o = '0;
    for (int i = 0; i <= NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_prio)) begin
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
        best_id_o = IDW'(i);
      end
    end
  end

  assign irq_o = (best_id_o != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC              = 31,
  parameter int NCTX              = 2,
  parameter int PRIO_W            = 3,
  parameter int ADDR_W            = 22,
  parameter logic [NSRC:0] EDGE_SRCS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_data,
  output logic [NCTX-1:0]   irq_o
);
  localparam int IDW    = $clog2(NSRC + 1);
  localparam int NWORDS = (NSRC + 32) / 32;
  localparam int EW     = NWORDS * 32;

  logic [PRIO_W-1:0] prio_q [NSRC+1];
  logic [NSRC:0]     en_q   [NCTX];
  logic [PRIO_W-1:0] thr_q  [NCTX];

  logic [NSRC:0] pend_v, svc_v, claim_fire, done_fire;
  logic [(NSRC+1)*PRIO_W-1:0] prio_flat;
  logic [NCTX*PRIO_W-1:0]     thr_flat;
  logic [IDW-1:0] best_id [NCTX];

  logic acc, resp_valid_q;
  logic [31:0] resp_data_q, rd_n;
  logic [NSRC:0] prio_we;
  logic [NWORDS-1:0] ena_we [NCTX];
  logic [NCTX-1:0] thr_we;

  assign req_ready = ~resp_valid_q | resp_ready;
  assign acc       = req_valid & req_ready;

  // ---------------- gateways ----------------
  assign src_unused_zero = 1'b0;
  logic src_unused_zero;
  assign pend_v[0] = src_unused_zero;
  assign svc_v[0]  = 1'b0;

  generate
    for (genvar i = 1; i <= NSRC; i++) begin : g_gw
      irq_gateway #(.EDGE(EDGE_SRCS[i])) u_gw (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i[i]),
        .claim_i(claim_fire[i]),
        .done_i (done_fire[i]),
        .pend_o (pend_v[i]),
        .svc_o  (svc_v[i])
      );
    end
    for (genvar i = 0; i <= NSRC; i++) begin : g_pack
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end
  endgenerate

  // ---------------- per-context arbiters ----------------
  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      assign thr_flat[c*PRIO_W +: PRIO_W] = thr_q[c];
      ctx_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i   (pend_v),
        .en_i     (en_q[c]),
        .prio_i   (prio_flat),
        .thr_i    (thr_q[c]),
        .best_id_o(best_id[c]),
        .irq_o    (irq_o[c])
      );
    end
  endgenerate

  // ---------------- access decode ----------------
  always_comb begin
    rd_n       = '0;
    claim_fire = '0;
    done_fire  = '0;
    prio_we    = '0;
    thr_we     = '0;
    for (int c = 0; c < NCTX; c++) ena_we[c] = '0;

    if (acc) begin
      for (int i = 0; i <= NSRC; i++) begin
        if (req_addr == ADDR_W'(i)) begin
          if (req_write) prio_we[i] = (i != 0);
          else           rd_n = 32'(prio_q[i]);
        end
      end
      for (int c = 0; c < NCTX; c++) begin
        for (int w = 0; w < NWORDS; w++) begin
          if (req_addr == ADDR_W'(ENA_WBASE + ENA_WSTEP*c + w)) begin
            if (req_write) ena_we[c][w] = 1'b1;
            else           rd_n = (EW'(en_q[c]) >> (w*32)) & 32'hFFFF_FFFF;
          end
        end
        if (req_addr == ADDR_W'(CTX_WBASE + CTX_WSTEP*c + THR_OFS)) begin
          if (req_write) thr_we[c] = 1'b1;
          else           rd_n = 32'(thr_q[c]);
        end
        if (req_addr == ADDR_W'(CTX_WBASE + CTX_WSTEP*c + CLAIM_OFS)) begin
          if (req_write) begin
            for (int i = 1; i <= NSRC; i++)
              if (req_wdata == 32'(i) && en_q[c][i]) done_fire[i] = 1'b1;
          end else begin
            rd_n = 32'(best_id[c]);
            for (int i = 1; i <= NSRC; i++)
              if (best_id[c] == IDW'(i)) claim_fire[i] = 1'b1;
          end
        end
      end
    end
  end

  // ---------------- configuration state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NSRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else begin
      for (int i = 1; i <= NSRC; i++)
        if (prio_we[i]) prio_q[i] <= req_wdata[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (thr_we[c]) thr_q[c] <= req_wdata[PRIO_W-1:0];
        for (int i = 1; i <= NSRC; i++)
          if (ena_we[c][i/32]) en_q[c][i] <= req_wdata[i%32];
      end
    end
  end

  // ---------------- read response stage ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else if (acc && !req_write) begin
      resp_valid_q <= 1'b1;
      resp_data_q  <= rd_n;
    end else if (resp_ready) begin
      resp_valid_q <= 1'b0;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_data  = resp_data_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic                   resp_valid,
  input logic                   resp_ready,
  input logic [31:0]            resp_data,
  input logic [NCTX-1:0]        irq_o,
  input logic [NCTX*PRIO_W-1:0] thr_flat,
  input logic [NSRC:0]          pend_v,
  input logic [NSRC:0]          svc_v,
  input logic [NSRC:0]          claim_fire
);
  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data));

  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> resp_valid);

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_c
      // R4
      thr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flat[c*PRIO_W +: PRIO_W] == {PRIO_W{1'b1}}) |-> !irq_o[c]);
    end
    for (genvar i = 1; i <= NSRC; i++) begin : g_s
      // R5
      claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire[i] |=> !pend_v[i]);
      // R5
      claim_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire[i] |-> pend_v[i]);
      // R6
      no_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_v[i] && !pend_v[i] |=> !pend_v[i]);
    end
  endgenerate
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready),
  .resp_data (resp_data),
  .irq_o     (irq_o),
  .thr_flat  (thr_flat),
  .pend_v    (pend_v),
  .svc_v     (svc_v),
  .claim_fire(claim_fire)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam int AW   = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC:1] src = '0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [31:0] resp_data;
  logic [NCTX-1:0] irq;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(AW),
                  .EDGE_SRCS(32'hFFFF_0000)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .irq_o(irq));

  function automatic int ena(int c, int w); return 'h800 + 'h20*c + w; endfunction
  function automatic int thr(int c);        return 'h80000 + 'h400*c; endfunction
  function automatic int clm(int c);        return 'h80000 + 'h400*c + 1; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = 32'(d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (resp_valid && resp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual unexpected response %0d expected none", resp_data);
      end else begin
        chk(tag_q.pop_front(), int'(resp_data), exp_q.pop_front());
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq after reset", int'(irq), 0);
    rd(clm(0), 0, "R1 claim empty");
    rd(5, 0, "R1 priority reset");
    rd(thr(1), 0, "R1 threshold reset");

    // R2
    wr(5, 3);           rd(5, 3, "R2 priority readback");
    wr(5, 'hF);         rd(5, 7, "R2 priority width");
    wr(0, 5);           rd(0, 0, "R2 word zero");
    rd('h1000, 0, "R2 unmapped read");
    wr(5, 0);

    // R3
    wr(ena(0,0), 'hFFFF_FFFF); rd(ena(0,0), 'hFFFF_FFFE, "R3 enable bit0 fixed");
    wr(ena(0,0), 0);           rd(ena(0,0), 0, "R3 enable cleared");

    // R4 setup: levels 3 (p2), 4 (p5), 6 (p5) enabled on ctx0
    wr(3, 2); wr(4, 5); wr(6, 5); wr(ena(0,0), 'h58);
    @(negedge clk); src[3] = 1'b1;
    settle();
    chk("R4 irq raised", int'(irq[0]), 1);
    chk("R4 other context not enabled", int'(irq[1]), 0);
    wr(thr(0), 2); settle(); chk("R4 strict threshold", int'(irq[0]), 0);
    wr(thr(0), 1); settle(); chk("R4 above threshold", int'(irq[0]), 1);
    @(negedge clk); src[4] = 1'b1; src[6] = 1'b1;
    wr(thr(0), 7); settle(); chk("R4 threshold 7 masks", int'(irq[0]), 0);
    wr(thr(0), 0); settle();

    // R5
    rd(clm(0), 4, "R5 tie goes to lower id");
    rd(clm(0), 6, "R5 second of tie");
    rd(clm(0), 3, "R5 lower priority last");
    rd(clm(0), 0, "R5 nothing left");
    settle();
    chk("R6 held level not pending", int'(irq[0]), 0);

    // R6
    wr(clm(0), 6); settle();
    rd(clm(0), 6, "R6 re-pends after completion");

    // R8
    wr(clm(1), 4); wr(clm(0), 40); wr(clm(0), 0); settle();
    rd(clm(0), 0, "R8 foreign or bad completion ignored");
    wr(clm(0), 4); settle();
    rd(clm(0), 4, "R8 valid completion accepted");
    @(negedge clk); src[3] = 1'b0; src[4] = 1'b0; src[6] = 1'b0;
    wr(clm(0), 3); wr(clm(0), 4); wr(clm(0), 6); settle();
    rd(clm(0), 0, "R6 lines low stay idle");

    // R9
    wr(7, 0); wr(ena(0,0), 'h80);
    @(negedge clk); src[7] = 1'b1;
    settle();
    chk("R9 zero priority silent", int'(irq[0]), 0);
    rd(clm(0), 0, "R9 zero priority not claimed");
    @(negedge clk); src[7] = 1'b0;
    wr(7, 1); settle();
    chk("R9 nonzero priority raises", int'(irq[0]), 1);
    rd(clm(0), 7, "R9 claim after priority set");
    wr(clm(0), 7); wr(7, 0);

    // R7: edge source 20 on ctx1
    wr(20, 4); wr(ena(1,0), 1 << 20);
    @(negedge clk); src[20] = 1'b1; @(negedge clk); src[20] = 1'b0;
    settle();
    chk("R7 edge raises", int'(irq[1]), 1);
    rd(clm(1), 20, "R7 edge claimed");
    @(negedge clk); src[20] = 1'b1; @(negedge clk); src[20] = 1'b0;
    settle();
    chk("R7 edge held during service", int'(irq[1]), 0);
    rd(clm(1), 0, "R7 edge not forwarded early");
    wr(clm(1), 20); settle();
    chk("R7 edge forwarded after completion", int'(irq[1]), 1);
    rd(clm(1), 20, "R7 latched edge claimed");
    wr(clm(1), 20); settle();
    rd(clm(1), 0, "R7 single latched edge");

    // R10 back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    exp_q.push_back(5); tag_q.push_back("R10 stalled data delivered");
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(4);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response valid", int'(resp_valid), 1);
    chk("R10 request blocked", int'(req_ready), 0);
    @(negedge clk);
    chk("R10 data held", int'(resp_data), 5);
    @(posedge clk); #1 resp_ready = 1'b1;
    settle();

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: actual %0d responses missing expected 0", exp_q.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule